// File: doc/BRIEF.md
# Slot Power Limit Message Handler

This block handles the slot power limit message for one port of a packet switch. The port can work as an upstream port or as a downstream port. The `dn_mode` input selects which.

As an upstream port, the block takes a received slot power limit message and copies two fields of its 32-bit payload into a captured power limit image. That image is the port's device capabilities view. Payload byte 0 fills the 8-bit captured scale field. The two low bits of payload byte 1 fill the 2-bit captured value field.

As a downstream port, the block asks a message transmitter to send a slot power limit message when either of two things happens:

- configuration software writes the slot capabilities register while the link is up;
- the data link comes up.

The link counts as up in the fully operational state, both low power states, and the state that is ready for power removal. It counts as down in the transitional link-down pseudo-state. The `dl_up` input already reflects this split.

A request is held on `tx_req` until the transmitter acknowledges it. Triggers that arrive while a request is pending fold into that request. The outgoing payload is a snapshot of the slot capabilities contents, taken in the cycle the request is raised.

Top module: `spl_msg_port`

## Requirements
- R1: While `rst` is high at a clock edge, `cap_scale`, `cap_value`, `tx_req` and `tx_payload` all become zero, including when a request is pending.
- R2: In upstream mode (`dn_mode`=0), a cycle with `rx_spl_valid` high loads `cap_scale` from payload bits 7:0 and `cap_value` from payload bits 9:8. The new values are visible after that clock edge. All other payload bits have no effect.
- R3: In downstream mode (`dn_mode`=1), a received message has no effect on `cap_scale` or `cap_value`.
- R4: In downstream mode, a `cfg_slot_wr` pulse while the registered link status is up raises `tx_req` at the next clock edge.
- R5: A `cfg_slot_wr` pulse while the link is down raises no request. It is not remembered, so a later link-up produces only its own single request.
- R6: `dl_up` is registered once. A low-to-high change of that registered value raises `tx_req` one edge later, so `tx_req` is high two edges after `dl_up` is first sampled high. A link that stays up produces no further requests. A falling link produces none.
- R7: `tx_req` stays high and `tx_payload` stays stable until a clock edge samples `tx_ack` high with `tx_req` high. After that edge, `tx_req` is low. `tx_ack` with no pending request has no effect.
- R8: Any trigger in a cycle where `tx_req` is already high is absorbed. It makes no second request and leaves `tx_payload` unchanged.
- R9: When a request is raised, `tx_payload` is loaded as follows: bits 7:0 from `slot_scale` and bits 9:8 from `slot_value`, both as sampled at that edge. Bits 31:10 are zero.
- R10: In upstream mode, configuration writes and link-up changes never raise `tx_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dn_mode | input | 1 | 1 = downstream port, 0 = upstream port |
| rx_spl_valid | input | 1 | Strobe for a received slot power limit message |
| rx_spl_payload | input | 32 | Payload of the received message |
| cfg_slot_wr | input | 1 | Configuration write to the slot capabilities register |
| slot_scale | input | 8 | Current scale contents of the slot capabilities register |
| slot_value | input | 2 | Current value contents of the slot capabilities register |
| dl_up | input | 1 | Data link layer up |
| cap_scale | output | 8 | Captured power limit scale field |
| cap_value | output | 2 | Captured power limit value field |
| tx_req | output | 1 | Request to send a slot power limit message |
| tx_ack | input | 1 | Transmitter has taken the request |
| tx_payload | output | 32 | Payload for the outgoing message |

## Verification
The bench targets payload patterns whose unused bits are all ones. A capture that used the wrong byte, or took more than two bits into the value field, would show corrupted fields. It switches between modes, to catch a design that captures while downstream or requests while upstream. It checks exactly two edges of latency after the link comes up, and it checks that a configuration write made while the link was down leaves no queued request behind. It also writes new slot contents while a request is pending. A design that re-sampled them would change the payload, and a design that queued a second message would raise `tx_req` again after the acknowledge.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int SPL_PAY_W     = 32;
  localparam int SPL_SCALE_W   = 8;
  localparam int SPL_VALUE_W   = 2;
  localparam int SPL_SCALE_LSB = 0;
  localparam int SPL_VALUE_LSB = 8;

  typedef logic [SPL_PAY_W-1:0]   spl_payload_t;
  typedef logic [SPL_SCALE_W-1:0] spl_scale_t;
  typedef logic [SPL_VALUE_W-1:0] spl_value_t;

  typedef struct packed {
    spl_scale_t scale;
    spl_value_t value;
  } spl_limit_t;

  typedef enum logic {
    SPL_IDLE = 1'b0,
    SPL_PEND = 1'b1
  } spl_req_state_e;

  // Field extraction from a received payload
  function automatic spl_scale_t spl_get_scale(input spl_payload_t p);
    return p[SPL_SCALE_LSB +: SPL_SCALE_W];
  endfunction

  function automatic spl_value_t spl_get_value(input spl_payload_t p);
    return p[SPL_VALUE_LSB +: SPL_VALUE_W];
  endfunction

  // Build an outgoing payload; unused bits are zero
  function automatic spl_payload_t spl_pack_payload(input spl_limit_t lim);
    spl_payload_t p;
    p = '0;
    p[SPL_SCALE_LSB +: SPL_SCALE_W] = lim.scale;
    p[SPL_VALUE_LSB +: SPL_VALUE_W] = lim.value;
    return p;
  endfunction
endpackage

// File: rtl/spl_rx_capture.sv
module spl_rx_capture
  import spl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         capture_en,
  input  spl_payload_t payload,
  output spl_limit_t   captured
);
  always_ff @(posedge clk) begin
    if (rst) begin
      captured <= '0;
    end else if (capture_en) begin
      captured.scale <= spl_get_scale(payload);
      captured.value <= spl_get_value(payload);
    end
  end
endmodule

// File: rtl/spl_link_edge.sv
module spl_link_edge #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic dl_up,
  output logic link_up_q,
  output logic link_rise
);
  logic [STAGES-1:0] stg;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg    <= '0;
      prev_q <= 1'b0;
    end else begin
      stg[0] <= dl_up;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
      prev_q <= stg[STAGES-1];
    end
  end

  assign link_up_q = stg[STAGES-1];
  assign link_rise = link_up_q & ~prev_q;
endmodule

// File: rtl/spl_tx_request.sv
module spl_tx_request
  import spl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         dn_mode,
  input  logic         cfg_wr,
  input  logic         link_up_q,
  input  logic         link_rise,
  input  spl_limit_t   slot_lim,
  input  logic         tx_ack,
  output logic         cfg_trig,
  output logic         edge_trig,
  output logic         tx_req,
  output spl_payload_t tx_payload
);
  spl_req_state_e state_q;
  logic           any_trig;

  assign cfg_trig  = dn_mode & cfg_wr & link_up_q;
  assign edge_trig = dn_mode & link_rise;
  assign any_trig  = cfg_trig | edge_trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SPL_IDLE;
      tx_payload <= '0;
    end else begin
      unique case (state_q)
        SPL_IDLE: begin
          if (any_trig) begin
            state_q    <= SPL_PEND;
            tx_payload <= spl_pack_payload(slot_lim);
          end
        end
        SPL_PEND: begin
          if (tx_ack) state_q <= SPL_IDLE;
        end
        default: state_q <= SPL_IDLE;
      endcase
    end
  end

  assign tx_req = (state_q == SPL_PEND);
endmodule

// File: rtl/spl_msg_port.sv
module spl_msg_port
  import spl_pkg::*;
#(
  parameter int LINK_STAGES = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dn_mode,
  input  logic                   rx_spl_valid,
  input  logic [SPL_PAY_W-1:0]   rx_spl_payload,
  input  logic                   cfg_slot_wr,
  input  logic [SPL_SCALE_W-1:0] slot_scale,
  input  logic [SPL_VALUE_W-1:0] slot_value,
  input  logic                   dl_up,
  output logic [SPL_SCALE_W-1:0] cap_scale,
  output logic [SPL_VALUE_W-1:0] cap_value,
  output logic                   tx_req,
  input  logic                   tx_ack,
  output logic [SPL_PAY_W-1:0]   tx_payload
);
  // Internal events, named for the checker
  logic       rx_capture_en;
  logic       link_up_q;
  logic       link_rise;
  logic       cfg_trig;
  logic       edge_trig;
  spl_limit_t cap_lim;
  spl_limit_t slot_lim;

  assign rx_capture_en  = rx_spl_valid & ~dn_mode;
  assign slot_lim.scale = slot_scale;
  assign slot_lim.value = slot_value;

  spl_rx_capture u_rx (
    .clk        (clk),
    .rst        (rst),
    .capture_en (rx_capture_en),
    .payload    (rx_spl_payload),
    .captured   (cap_lim)
  );

  spl_link_edge #(.STAGES(LINK_STAGES)) u_link (
    .clk       (clk),
    .rst       (rst),
    .dl_up     (dl_up),
    .link_up_q (link_up_q),
    .link_rise (link_rise)
  );

  spl_tx_request u_tx (
    .clk        (clk),
    .rst        (rst),
    .dn_mode    (dn_mode),
    .cfg_wr     (cfg_slot_wr),
    .link_up_q  (link_up_q),
    .link_rise  (link_rise),
    .slot_lim   (slot_lim),
    .tx_ack     (tx_ack),
    .cfg_trig   (cfg_trig),
    .edge_trig  (edge_trig),
    .tx_req     (tx_req),
    .tx_payload (tx_payload)
  );

  assign cap_scale = cap_lim.scale;
  assign cap_value = cap_lim.value;
endmodule

// File: rtl/spl_msg_port_chk.sv
module spl_msg_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        dn_mode,
  input logic        rx_spl_valid,
  input logic [31:0] rx_spl_payload,
  input logic [7:0]  slot_scale,
  input logic [1:0]  slot_value,
  input logic [7:0]  cap_scale,
  input logic [1:0]  cap_value,
  input logic        tx_req,
  input logic        tx_ack,
  input logic [31:0] tx_payload,
  input logic        cfg_trig,
  input logic        edge_trig
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!tx_req && cap_scale == 8'd0 && cap_value == 2'd0 && tx_payload == 32'd0));

  a_r2_up_capture: assert property (@(posedge clk) disable iff (rst)
    (rx_spl_valid && !dn_mode) |=>
      (cap_scale == $past(rx_spl_payload[7:0]) && cap_value == $past(rx_spl_payload[9:8])));

  a_r3_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !(rx_spl_valid && !dn_mode) |=> ($stable(cap_scale) && $stable(cap_value)));

  a_r4_cfg_raises: assert property (@(posedge clk) disable iff (rst)
    (cfg_trig && !tx_req) |=> tx_req);

  a_r6_edge_raises: assert property (@(posedge clk) disable iff (rst)
    (edge_trig && !tx_req) |=> tx_req);

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_ack) |=> (tx_req && $stable(tx_payload)));

  a_r7_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_ack) |=> !tx_req);

  a_r8_pending_payload_fixed: assert property (@(posedge clk) disable iff (rst)
    (tx_req && (cfg_trig || edge_trig)) |=> $stable(tx_payload));

  a_r9_payload_snapshot: assert property (@(posedge clk) disable iff (rst)
    ((cfg_trig || edge_trig) && !tx_req) |=>
      (tx_payload[7:0] == $past(slot_scale) && tx_payload[9:8] == $past(slot_value)
       && tx_payload[31:10] == 22'd0));

  a_r10_up_no_request: assert property (@(posedge clk) disable iff (rst)
    (!dn_mode && !tx_req) |=> !tx_req);
endmodule

bind spl_msg_port spl_msg_port_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .dn_mode        (dn_mode),
  .rx_spl_valid   (rx_spl_valid),
  .rx_spl_payload (rx_spl_payload),
  .slot_scale     (slot_scale),
  .slot_value     (slot_value),
  .cap_scale      (cap_scale),
  .cap_value      (cap_value),
  .tx_req         (tx_req),
  .tx_ack         (tx_ack),
  .tx_payload     (tx_payload),
  .cfg_trig       (cfg_trig),
  .edge_trig      (edge_trig)
);

// File: tb/sim_spl_msg_port.sv
`timescale 1ns/1ps
module sim_spl_msg_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        dn_mode;
  logic        rx_spl_valid;
  logic [31:0] rx_spl_payload;
  logic        cfg_slot_wr;
  logic [7:0]  slot_scale;
  logic [1:0]  slot_value;
  logic        dl_up;
  logic [7:0]  cap_scale;
  logic [1:0]  cap_value;
  logic        tx_req;
  logic        tx_ack;
  logic [31:0] tx_payload;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spl_msg_port u0 (
    .clk(clk), .rst(rst), .dn_mode(dn_mode), .rx_spl_valid(rx_spl_valid),
    .rx_spl_payload(rx_spl_payload), .cfg_slot_wr(cfg_slot_wr),
    .slot_scale(slot_scale), .slot_value(slot_value), .dl_up(dl_up),
    .cap_scale(cap_scale), .cap_value(cap_value), .tx_req(tx_req),
    .tx_ack(tx_ack), .tx_payload(tx_payload)
  );

  // Vector table: mode, received payload, expected captured fields
  localparam int NV = 7;
  localparam logic        V_MODE [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0] V_PAY  [NV] = '{32'h0000_03A5, 32'hFFFF_FC5A, 32'h0000_0277,
                                          32'h1234_0181, 32'hFFFF_FFFF, 32'h0000_0200,
                                          32'hABCD_EF01};
  localparam logic [7:0]  V_SCL  [NV] = '{8'hA5, 8'h5A, 8'h5A, 8'h81, 8'h81, 8'h00, 8'h01};
  localparam logic [1:0]  V_VAL  [NV] = '{2'd3, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd3};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; dn_mode = 1'b0; rx_spl_valid = 1'b0; rx_spl_payload = '0;
    cfg_slot_wr = 1'b0; slot_scale = '0; slot_value = '0; dl_up = 1'b0; tx_ack = 1'b0;
    repeat (3) step();
    chk("R1 cap_scale", {24'd0, cap_scale}, 32'd0);
    chk("R1 cap_value", {30'd0, cap_value}, 32'd0);
    chk("R1 tx_req", {31'd0, tx_req}, 32'd0);
    chk("R1 tx_payload", tx_payload, 32'd0);
    rst = 1'b0;
    step();

    // Table walk: R2 captures in upstream mode, R3 ignores in downstream mode
    for (int i = 0; i < NV; i++) begin
      dn_mode = V_MODE[i]; rx_spl_valid = 1'b1; rx_spl_payload = V_PAY[i];
      step();
      rx_spl_valid = 1'b0; rx_spl_payload = 32'hDEAD_BEEF;
      chk(V_MODE[i] ? "R3 cap_scale" : "R2 cap_scale", {24'd0, cap_scale}, {24'd0, V_SCL[i]});
      chk(V_MODE[i] ? "R3 cap_value" : "R2 cap_value", {30'd0, cap_value}, {30'd0, V_VAL[i]});
      chk("R10 no request from receive", {31'd0, tx_req}, 32'd0);
    end

    // R5: configuration write while link down is dropped
    dn_mode = 1'b1; dl_up = 1'b0; slot_scale = 8'h3C; slot_value = 2'd2;
    cfg_slot_wr = 1'b1;
    step();
    cfg_slot_wr = 1'b0;
    chk("R5 write while down", {31'd0, tx_req}, 32'd0);
    repeat (3) step();
    chk("R5 not queued", {31'd0, tx_req}, 32'd0);

    // R6: link-up latency of two edges
    dl_up = 1'b1;
    step();
    chk("R6 one edge after up", {31'd0, tx_req}, 32'd0);
    step();
    chk("R6 two edges after up", {31'd0, tx_req}, 32'd1);
    chk("R9 payload on link up", tx_payload, 32'h0000_023C);

    // R8: trigger while pending is absorbed
    slot_scale = 8'h11; slot_value = 2'd1; cfg_slot_wr = 1'b1;
    step();
    cfg_slot_wr = 1'b0;
    chk("R8 payload unchanged", tx_payload, 32'h0000_023C);
    repeat (4) step();
    chk("R7 held without ack", {31'd0, tx_req}, 32'd1);

    tx_ack = 1'b1;
    step();
    tx_ack = 1'b0;
    chk("R7 ack drops", {31'd0, tx_req}, 32'd0);
    repeat (4) step();
    chk("R8 no second request", {31'd0, tx_req}, 32'd0);

    // R4: configuration write while link up
    cfg_slot_wr = 1'b1;
    step();
    cfg_slot_wr = 1'b0;
    chk("R4 write while up", {31'd0, tx_req}, 32'd1);
    chk("R9 payload on write", tx_payload, 32'h0000_0111);
    tx_ack = 1'b1;
    step();
    tx_ack = 1'b0;
    chk("R7 ack drops again", {31'd0, tx_req}, 32'd0);
    tx_ack = 1'b1;
    step();
    tx_ack = 1'b0;
    chk("R7 ack idle no effect", {31'd0, tx_req}, 32'd0);

    // R6: link down makes no request, re-up makes one
    dl_up = 1'b0;
    repeat (3) step();
    chk("R6 no request on fall", {31'd0, tx_req}, 32'd0);
    dl_up = 1'b1; slot_scale = 8'hF0; slot_value = 2'd3;
    repeat (2) step();
    chk("R6 request on re-up", {31'd0, tx_req}, 32'd1);
    chk("R9 payload on re-up", tx_payload, 32'h0000_03F0);
    tx_ack = 1'b1;
    step();
    tx_ack = 1'b0;

    // R10: upstream mode never requests
    dn_mode = 1'b0; dl_up = 1'b0;
    repeat (3) step();
    dl_up = 1'b1; cfg_slot_wr = 1'b1;
    step();
    cfg_slot_wr = 1'b0;
    repeat (3) step();
    chk("R10 no upstream request", {31'd0, tx_req}, 32'd0);
    cfg_slot_wr = 1'b1;
    step();
    cfg_slot_wr = 1'b0;
    chk("R10 write while up upstream", {31'd0, tx_req}, 32'd0);

    // R1: reset clears a pending request and captured fields
    dn_mode = 1'b1; cfg_slot_wr = 1'b1;
    step();
    cfg_slot_wr = 1'b0;
    chk("R4 write before reset", {31'd0, tx_req}, 32'd1);
    dl_up = 1'b0; rst = 1'b1;
    step();
    chk("R1 pending cleared", {31'd0, tx_req}, 32'd0);
    chk("R1 payload cleared", tx_payload, 32'd0);
    chk("R1 scale cleared", {24'd0, cap_scale}, 32'd0);
    chk("R1 value cleared", {30'd0, cap_value}, 32'd0);
    rst = 1'b0;
    repeat (3) step();
    chk("R1 idle after reset", {31'd0, tx_req}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule